// File: doc/BRIEF.md
# PHY Reset and Power-Down Sequencer

This block sits between a software-visible request register and the reset and power-down pins of a multi-lane PHY. The PHY has one common clock unit (CMU) and a set of lanes, two by default. Software writes a requested state in one strobe. That state covers a global power-on reset, plus a reset and a 2-bit power-down level for the CMU and for each lane.

The request is held in a register. Each unit's PHY-facing reset and power-down pins take the held request only in a cycle where that unit's ready status is high. While a unit is not ready, its pins are frozen. Any later write overwrites the held request, so the pending value is always the most recent one. On the first ready cycle that latest value is applied.

A requested power-on reset has priority over everything. All unit resets are driven low and all power-down levels are driven to 0, whatever the ready bits say. A power-down level is also forced to 0 whenever the unit's own reset is requested.

The PHY's error, ready and PLL-ok wires are registered into a status word for software to read.

Top module: `phy_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises with no write, the block drives these outputs: `phy_por_n`=0, `phy_cmu_rst_n`=0, `phy_cmu_pd`=0, `phy_ln_rst_n`=0, `phy_ln_pd`=0 and `status`=0.
- R2: When `wr_en` is high at a rising edge, the written values are captured. `phy_por_n` shows the written power-on reset bit after the next rising edge, independent of any ready input.
- R3: With the power-on reset released (held request 1) and a unit's ready input high at a rising edge, that unit's reset and power-down outputs take the held request at that edge. Power-down levels 0 to 3 (0 active, 1 partial, 2 deep, 3 full off) pass through unchanged.
- R4: While the held power-on reset request is 0, every unit reset output is 0 and every power-down output is 0 after the next edge. This holds regardless of the ready inputs and of the other requested values.
- R5: While a unit's ready input is low and the power-on reset is released, that unit's reset and power-down outputs do not change, even when new requests are written.
- R6: If several writes occur while a unit is not ready, the first edge with ready high applies only the most recently written values for that unit.
- R7: A unit whose requested reset is 0 drives a power-down output of 0, whatever power-down level was requested.
- R8: `status` is registered one edge after the PHY inputs. Bit 0 is `phy_err`, bit 1 is `phy_cmu_ready`, bit 2 is `phy_cmu_ok`, and bit 3+i is `phy_ln_ready[i]`.
- R9: The ready input of one unit does not gate any other unit. A ready lane applies its request while the CMU or another lane is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| wr_en | input | 1 | Request register write strobe |
| wr_por_n | input | 1 | Requested power-on reset, active low |
| wr_cmu_rst_n | input | 1 | Requested CMU reset, active low |
| wr_cmu_pd | input | 2 | Requested CMU power-down level |
| wr_ln_rst_n | input | 2 | Requested lane resets, bit i for lane i, active low |
| wr_ln_pd | input | 4 | Requested lane power-down levels, bits 2i+1:2i for lane i |
| phy_err | input | 1 | PHY internal error |
| phy_cmu_ready | input | 1 | CMU accepts reset/power-down change |
| phy_cmu_ok | input | 1 | CMU PLL locked, clocks correct |
| phy_ln_ready | input | 2 | Lane i accepts reset/power-down change |
| phy_por_n | output | 1 | Power-on reset to PHY, active low |
| phy_cmu_rst_n | output | 1 | CMU reset to PHY, active low |
| phy_cmu_pd | output | 2 | CMU power-down level to PHY |
| phy_ln_rst_n | output | 2 | Lane resets to PHY |
| phy_ln_pd | output | 4 | Lane power-down levels to PHY |
| status | output | 5 | Registered PHY status flags |

## Verification
The gating is tried with every unit ready, with only the CMU held, and with all units held while power-on reset is requested.

- The all-ready pattern separates correct pass-through of each power-down level from any mix-up between units.
- The CMU-held pattern shows that the held unit freezes, that lanes still move, and that the last of several pending writes wins.
- The all-held pattern shows that power-on reset overrides the handshake.

Status is driven with single-bit and mixed patterns, so that a swapped or shifted bit position is caught.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;
  localparam int PD_W = 2;

  typedef struct packed {
    logic            rst_n;
    logic [PD_W-1:0] pd;
  } unit_ctrl_t;

  localparam unit_ctrl_t CTRL_RESET = '{rst_n: 1'b0, pd: '0};

  // A unit held in reset may not be asked for a power-down level.
  function automatic unit_ctrl_t legal_ctrl(unit_ctrl_t req);
    unit_ctrl_t r;
    r = req;
    if (!req.rst_n) r.pd = '0;
    return r;
  endfunction

  // Value a unit's pins take at the next edge.
  function automatic unit_ctrl_t next_ctrl(unit_ctrl_t cur, unit_ctrl_t req,
                                           logic por_n, logic ready);
    if (!por_n)     return CTRL_RESET;
    else if (ready) return legal_ctrl(req);
    else            return cur;
  endfunction
endpackage

// File: rtl/phy_req_reg.sv
module phy_req_reg
  import phy_pwr_pkg::*;
#(
  parameter int NUM_UNITS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        wr_por_n,
  input  unit_ctrl_t [NUM_UNITS-1:0]  wr_ctrl,
  output logic                        req_por_n,
  output unit_ctrl_t [NUM_UNITS-1:0]  req_ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_por_n <= 1'b0;
      req_ctrl  <= {NUM_UNITS{CTRL_RESET}};
    end else if (wr_en) begin
      req_por_n <= wr_por_n;
      req_ctrl  <= wr_ctrl;
    end
  end
endmodule

// File: rtl/phy_unit_gate.sv
module phy_unit_gate
  import phy_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_req_n,
  input  logic       ready,
  input  unit_ctrl_t req,
  output unit_ctrl_t ctrl_q
);
  logic apply_ev;
  logic force_ev;
  assign apply_ev = por_req_n && ready;
  assign force_ev = !por_req_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RESET;
    else        ctrl_q <= next_ctrl(ctrl_q, req, por_req_n, ready);
  end

  AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!apply_ev && !force_ev) |=> $stable(ctrl_q)); // R5
  AST_POR_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    force_ev |=> (ctrl_q.rst_n == 1'b0 && ctrl_q.pd == '0)); // R4
  AST_PD_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.pd != '0) |-> ctrl_q.rst_n); // R7
endmodule

// File: rtl/phy_status_pack.sv
module phy_status_pack #(
  parameter int NUM_LANES = 2,
  localparam int ST_W = 3 + NUM_LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 err,
  input  logic                 cmu_ready,
  input  logic                 cmu_ok,
  input  logic [NUM_LANES-1:0] ln_ready,
  output logic [ST_W-1:0]      status_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= {ln_ready, cmu_ok, cmu_ready, err};
  end

  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |=> status_q[0]); // R8
  AST_OK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmu_ok) |=> !status_q[2]); // R8
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_pwr_pkg::*;
#(
  parameter int NUM_LANES = 2,
  localparam int NUM_UNITS = NUM_LANES + 1,
  localparam int ST_W = 3 + NUM_LANES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      wr_por_n,
  input  logic                      wr_cmu_rst_n,
  input  logic [PD_W-1:0]           wr_cmu_pd,
  input  logic [NUM_LANES-1:0]      wr_ln_rst_n,
  input  logic [NUM_LANES*PD_W-1:0] wr_ln_pd,
  input  logic                      phy_err,
  input  logic                      phy_cmu_ready,
  input  logic                      phy_cmu_ok,
  input  logic [NUM_LANES-1:0]      phy_ln_ready,
  output logic                      phy_por_n,
  output logic                      phy_cmu_rst_n,
  output logic [PD_W-1:0]           phy_cmu_pd,
  output logic [NUM_LANES-1:0]      phy_ln_rst_n,
  output logic [NUM_LANES*PD_W-1:0] phy_ln_pd,
  output logic [ST_W-1:0]           status
);
  // Unit 0 is the CMU, unit i+1 is lane i.
  unit_ctrl_t [NUM_UNITS-1:0] wr_ctrl;
  unit_ctrl_t [NUM_UNITS-1:0] req_ctrl;
  unit_ctrl_t [NUM_UNITS-1:0] out_ctrl;
  logic [NUM_UNITS-1:0]       unit_ready;
  logic                       req_por_n;

  assign wr_ctrl[0]    = '{rst_n: wr_cmu_rst_n, pd: wr_cmu_pd};
  assign unit_ready[0] = phy_cmu_ready;

  genvar g;
  generate
    for (g = 0; g < NUM_LANES; g++) begin : g_lane_map
      assign wr_ctrl[g+1]    = '{rst_n: wr_ln_rst_n[g], pd: wr_ln_pd[g*PD_W +: PD_W]};
      assign unit_ready[g+1] = phy_ln_ready[g];
      assign phy_ln_rst_n[g] = out_ctrl[g+1].rst_n;
      assign phy_ln_pd[g*PD_W +: PD_W] = out_ctrl[g+1].pd;
    end
  endgenerate

  assign phy_cmu_rst_n = out_ctrl[0].rst_n;
  assign phy_cmu_pd    = out_ctrl[0].pd;

  phy_req_reg #(.NUM_UNITS(NUM_UNITS)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_por_n  (wr_por_n),
    .wr_ctrl   (wr_ctrl),
    .req_por_n (req_por_n),
    .req_ctrl  (req_ctrl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phy_por_n <= 1'b0;
    else        phy_por_n <= req_por_n;
  end

  generate
    for (g = 0; g < NUM_UNITS; g++) begin : g_unit
      phy_unit_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_req_n (req_por_n),
        .ready     (unit_ready[g]),
        .req       (req_ctrl[g]),
        .ctrl_q    (out_ctrl[g])
      );
    end
  endgenerate

  phy_status_pack #(.NUM_LANES(NUM_LANES)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .err       (phy_err),
    .cmu_ready (phy_cmu_ready),
    .cmu_ok    (phy_cmu_ok),
    .ln_ready  (phy_ln_ready),
    .status_q  (status)
  );

  AST_POR_ALL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_por_n |-> (phy_cmu_rst_n == 1'b0 && phy_ln_rst_n == '0 &&
                    phy_cmu_pd == '0 && phy_ln_pd == '0)); // R4
  AST_LANE_PD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_ln_rst_n[0] == 1'b0) |-> (phy_ln_pd[PD_W-1:0] == '0)); // R7
endmodule

// File: tb/phy_pwr_seq_test.sv
module phy_pwr_seq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_por_n = 1'b0, wr_cmu_rst_n = 1'b0;
  logic [1:0] wr_cmu_pd = '0, wr_ln_rst_n = '0;
  logic [3:0] wr_ln_pd = '0;
  logic       phy_err = 1'b0, phy_cmu_ready = 1'b0, phy_cmu_ok = 1'b0;
  logic [1:0] phy_ln_ready = '0;
  logic       phy_por_n, phy_cmu_rst_n;
  logic [1:0] phy_cmu_pd, phy_ln_rst_n;
  logic [3:0] phy_ln_pd;
  logic [4:0] status;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_pwr_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_por_n(wr_por_n),
    .wr_cmu_rst_n(wr_cmu_rst_n), .wr_cmu_pd(wr_cmu_pd),
    .wr_ln_rst_n(wr_ln_rst_n), .wr_ln_pd(wr_ln_pd),
    .phy_err(phy_err), .phy_cmu_ready(phy_cmu_ready), .phy_cmu_ok(phy_cmu_ok),
    .phy_ln_ready(phy_ln_ready), .phy_por_n(phy_por_n),
    .phy_cmu_rst_n(phy_cmu_rst_n), .phy_cmu_pd(phy_cmu_pd),
    .phy_ln_rst_n(phy_ln_rst_n), .phy_ln_pd(phy_ln_pd), .status(status)
  );

  // Packed view of all PHY control outputs: {por, cmu_rst, cmu_pd, ln_rst, ln_pd}
  function automatic logic [9:0] outs();
    return {phy_por_n, phy_cmu_rst_n, phy_cmu_pd, phy_ln_rst_n, phy_ln_pd};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write strobe over one edge; outputs are then valid after one more edge.
  task automatic write_req(logic por, logic crst, logic [1:0] cpd,
                           logic [1:0] lrst, logic [3:0] lpd);
    @(negedge clk);
    wr_en = 1'b1; wr_por_n = por; wr_cmu_rst_n = crst; wr_cmu_pd = cpd;
    wr_ln_rst_n = lrst; wr_ln_pd = lpd;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 outputs", 32'(outs()), 32'h0);
    check("R1 status", 32'(status), 32'h0);
  endtask

  task automatic t_por();
    phy_cmu_ready = 1'b1; phy_ln_ready = 2'b11;
    write_req(1'b0, 1'b1, 2'd2, 2'b11, 4'b1111);
    @(negedge clk);
    check("R4 por overrides ready", 32'(outs()), 32'h0);
  endtask

  task automatic t_apply();
    write_req(1'b1, 1'b1, 2'd0, 2'b11, 4'b0000);
    check("R2 por not yet", 32'(phy_por_n), 32'h0);
    @(negedge clk);
    check("R2 por released", 32'(phy_por_n), 32'h1);
    check("R3 all running", 32'(outs()), 32'(10'b1_1_00_11_0000));
    write_req(1'b1, 1'b1, 2'd3, 2'b11, 4'b1001);
    @(negedge clk);
    check("R3 pd levels", 32'(outs()), 32'(10'b1_1_11_11_1001));
  endtask

  task automatic t_rst_pd();
    write_req(1'b1, 1'b0, 2'd3, 2'b10, 4'b0111);
    @(negedge clk);
    check("R7 pd masked in reset", 32'(outs()), 32'(10'b1_0_00_10_0100));
  endtask

  task automatic t_hold();
    write_req(1'b1, 1'b1, 2'd0, 2'b11, 4'b0000);
    @(negedge clk);
    phy_cmu_ready = 1'b0;
    write_req(1'b1, 1'b1, 2'd1, 2'b11, 4'b0110);
    @(negedge clk);
    check("R5 cmu held", 32'({phy_cmu_rst_n, phy_cmu_pd}), 32'(3'b1_00));
    check("R9 lanes move", 32'({phy_ln_rst_n, phy_ln_pd}), 32'(6'b11_0110));
    write_req(1'b1, 1'b1, 2'd2, 2'b11, 4'b0110);
    write_req(1'b1, 1'b0, 2'd3, 2'b11, 4'b0110);
    write_req(1'b1, 1'b1, 2'd3, 2'b11, 4'b0110);
    @(negedge clk);
    check("R5 cmu still held", 32'({phy_cmu_rst_n, phy_cmu_pd}), 32'(3'b1_00));
    phy_cmu_ready = 1'b1;
    @(negedge clk);
    check("R6 latest applied", 32'({phy_cmu_rst_n, phy_cmu_pd}), 32'(3'b1_11));
  endtask

  task automatic t_por_notready();
    phy_cmu_ready = 1'b0; phy_ln_ready = 2'b00;
    write_req(1'b0, 1'b1, 2'd3, 2'b11, 4'b1111);
    @(negedge clk);
    check("R4 por overrides hold", 32'(outs()), 32'h0);
    write_req(1'b1, 1'b1, 2'd1, 2'b11, 4'b0101);
    @(negedge clk);
    check("R5 no change after por, not ready", 32'(outs()), 32'(10'b1_0_00_00_0000));
    phy_ln_ready = 2'b10;
    @(negedge clk);
    check("R9 only lane1", 32'(outs()), 32'(10'b1_0_00_10_0100));
  endtask

  task automatic t_status();
    phy_err = 1'b1; phy_cmu_ready = 1'b0; phy_cmu_ok = 1'b0; phy_ln_ready = 2'b00;
    @(negedge clk);
    check("R8 err bit0", 32'(status), 32'h01);
    phy_err = 1'b0; phy_cmu_ok = 1'b1;
    @(negedge clk);
    check("R8 ok bit2", 32'(status), 32'h04);
    phy_cmu_ok = 1'b0; phy_ln_ready = 2'b10;
    @(negedge clk);
    check("R8 lane1 bit4", 32'(status), 32'h10);
    phy_cmu_ready = 1'b1; phy_ln_ready = 2'b01; phy_err = 1'b1;
    @(negedge clk);
    check("R8 mixed", 32'(status), 32'h0B);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 32'(outs()), 32'h0);
    rst_n = 1'b1;
    t_reset();
    t_por();
    t_apply();
    t_rst_pd();
    t_hold();
    t_por_notready();
    t_status();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule